// File: doc/BRIEF.md
# Serially Refreshed Watchdog Timer

This block is a watchdog that the host keeps alive over a serial register link. Every valid command frame carries one watchdog bit. The watchdog counts as serviced when that bit differs from the bit in the previous valid frame. It does not matter which register the frame addresses. A frame sent only as filler through a daisy chain also services the watchdog, provided its bit flips. When no service arrives within the selected period, a sticky timeout flag is raised.

The period is chosen by a 2-bit code that is written through a configuration strobe. The code-to-period mapping is not monotonic. A newly written code does not cut into the running sequence. It takes effect when the next count sequence starts, and a sequence starts on a service toggle. Time is measured in pulses of a 1 ms tick input, so a bench can scale the periods down through parameters. The last received watchdog bit is also driven out so that it can be returned as the most significant bit of the status word.

Top module: `wdt_serial_refresh`

## Requirements
- R1: After a synchronous reset, `expired` is 0, `wd_state` is 0 and the active timeout code is 00.
- R2: Timeout code 00 gives PER_00 ticks, 01 gives PER_01, 10 gives PER_10 and 11 gives PER_11 (620, 310, 2500 and 1250 by default). `expired` rises with the tick that completes the period counted from the last service and stays low through all the ticks before it.
- R3: A service is a cycle in which `frame_ok` is 1 and `frame_wd` differs from `wd_state`. A service restarts the count from zero and clears `expired`.
- R4: A valid frame whose watchdog bit equals `wd_state` (for example a no-operation filler frame) neither restarts the count nor clears `expired`.
- R5: `wd_state` takes the value of `frame_wd` on every valid frame. While `frame_ok` is 0, `wd_state` holds its value whatever `frame_wd` does.
- R6: A write on `cfg_wr` without a service in the same cycle does not change the period of the running sequence. The written code becomes active at the next service.
- R7: A write on `cfg_wr` in the same cycle as a service makes the written code the period of the sequence that this service starts.
- R8: Once `expired` is 1, it stays 1 through further ticks and non-toggling frames until a service or a reset.
- R9: When a service and a tick arrive in the same cycle, the service wins: that tick is not counted in the new sequence.
- R10: The count advances only in cycles where `tick_ms` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| frame_ok | input | 1 | Strobe: a valid command frame has completed |
| frame_wd | input | 1 | Watchdog bit of that frame |
| cfg_wr | input | 1 | Strobe: write of the timeout code |
| cfg_sel | input | 2 | Timeout code being written |
| expired | output | 1 | Sticky timeout flag, registered |
| wd_state | output | 1 | Watchdog bit of the last valid frame, registered |

## Verification
Every input is taken in at one rising edge, and both outputs are registered. A service, a frame or a completing tick therefore shows up on `expired` and `wd_state` one edge after the cycle that presents it. The bench drives inputs on falling edges for exactly one cycle and samples on the following falling edge, after that single register stage. For each of the four codes it counts ticks from a service and checks `expired` both after period−1 ticks and after the period-th tick. This pins the timeout to the exact tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef logic [1:0] wdt_code_t;
  localparam int unsigned NUM_CODES = 4;
endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned PER_00 = 620,
  parameter int unsigned PER_01 = 310,
  parameter int unsigned PER_10 = 2500,
  parameter int unsigned PER_11 = 1250,
  parameter int unsigned CW     = 12
) (
  input  wdt_code_t         code,
  output logic [CW-1:0]     limit
);
  localparam int unsigned TBL [NUM_CODES] = '{PER_00, PER_01, PER_10, PER_11};

  logic [CW-1:0] tbl_w [NUM_CODES];

  // Non-monotonic code order is behaviour: index equals the code value.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
    assign tbl_w[g] = CW'(TBL[g]);
  end

  assign limit = tbl_w[code];
endmodule

// File: rtl/wdt_service_det.sv
module wdt_service_det
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frame_ok,
  input  logic      frame_wd,
  input  logic      cfg_wr,
  input  wdt_code_t cfg_sel,
  output logic      service,
  output logic      last_wd,
  output wdt_code_t active_code
);
  wdt_code_t pend_code;

  assign service = frame_ok && (frame_wd != last_wd);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_wd     <= 1'b0;
      pend_code   <= '0;
      active_code <= '0;
    end else begin
      if (frame_ok) last_wd <= frame_wd;
      if (cfg_wr)   pend_code <= cfg_sel;
      if (service)  active_code <= cfg_wr ? cfg_sel : pend_code;
    end
  end

  // R5: bit follows valid frames only
  a_r5_track: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> last_wd == $past(frame_wd));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |=> $stable(last_wd));
  // R6: period only changes at a service
  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    !service |=> $stable(active_code));
  // R7: same-cycle write is taken by the new sequence
  a_r7_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (service && cfg_wr) |=> active_code == $past(cfg_sel));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
      if (cnt == limit - 1'b1) expired <= 1'b1;
    end
  end

  a_r2_limit_nonzero: assert property (@(posedge clk) disable iff (rst)
    limit != '0);
  a_r2_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
  // R3: restart clears state
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!expired && cnt == '0));
  // R8: flag is sticky without restart
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && !restart) |=> expired);
  // R10: no progress without a tick
  a_r10_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/wdt_serial_refresh.sv
module wdt_serial_refresh
  import wdt_pkg::*;
#(
  parameter int unsigned PER_00 = 620,
  parameter int unsigned PER_01 = 310,
  parameter int unsigned PER_10 = 2500,
  parameter int unsigned PER_11 = 1250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       frame_ok,
  input  logic       frame_wd,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  output logic       expired,
  output logic       wd_state
);
  localparam int unsigned MAX_A = (PER_00 > PER_01) ? PER_00 : PER_01;
  localparam int unsigned MAX_B = (PER_10 > PER_11) ? PER_10 : PER_11;
  localparam int unsigned MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAX_P + 1);

  logic          service;
  wdt_code_t     active_code;
  logic [CW-1:0] limit;

  wdt_service_det u_svc (
    .clk         (clk),
    .rst         (rst),
    .frame_ok    (frame_ok),
    .frame_wd    (frame_wd),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .service     (service),
    .last_wd     (wd_state),
    .active_code (active_code)
  );

  wdt_period_sel #(
    .PER_00 (PER_00), .PER_01 (PER_01), .PER_10 (PER_10), .PER_11 (PER_11), .CW (CW)
  ) u_sel (
    .code  (active_code),
    .limit (limit)
  );

  wdt_counter #(.CW (CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (service),
    .tick    (tick_ms),
    .limit   (limit),
    .expired (expired)
  );

  // R1: clean state after reset
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!expired && !wd_state && active_code == 2'b00));
  // R4: non-toggling frame never clears the flag
  a_r4_no_clear: assert property (@(posedge clk) disable iff (rst)
    (expired && frame_ok && frame_wd == wd_state) |=> expired);
endmodule

// File: tb/tb_wdt_serial_refresh.sv
module tb_wdt_serial_refresh;
  localparam int CLK_PERIOD = 10;
  localparam int P0 = 7, P1 = 4, P2 = 13, P3 = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_ms = 0, frame_ok = 0, frame_wd = 0, cfg_wr = 0;
  logic [1:0] cfg_sel = 0;
  logic expired, wd_state;

  int n_chk = 0, n_fail = 0;
  logic wd_model = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_serial_refresh #(.PER_00(P0), .PER_01(P1), .PER_10(P2), .PER_11(P3)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .frame_ok(frame_ok), .frame_wd(frame_wd),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .expired(expired), .wd_state(wd_state));

  function automatic int per_of(input int c);
    case (c)
      0: return P0;
      1: return P1;
      2: return P2;
      default: return P3;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one-cycle stimulus, sampled after the edge that takes it
  task automatic cyc(input logic t, input logic f, input logic b, input logic w, input logic [1:0] s);
    tick_ms = t; frame_ok = f; frame_wd = b; cfg_wr = w; cfg_sel = s;
    @(negedge clk);
    tick_ms = 0; frame_ok = 0; cfg_wr = 0;
    if (f) wd_model = b;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 2'b00);
  endtask

  task automatic service_with_cfg(input logic [1:0] c);
    cyc(0, 1, ~wd_model, 1, c);
  endtask

  task automatic service();
    cyc(0, 1, ~wd_model, 0, 2'b00);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 expired after reset", expired, 1'b0);
    chk("R1 wd_state after reset", wd_state, 1'b0);
    // R1: default code 00 -> P0 ticks (count started at reset)
    ticks(P0 - 1);
    chk("R1 default code not yet expired", expired, 1'b0);
    ticks(1);
    chk("R1 default code expired at P0", expired, 1'b1);

    // R2/R7/R3: sweep all codes, write with toggle
    for (int c = 0; c < 4; c++) begin
      service_with_cfg(2'(c));
      chk("R3 service clears flag", expired, 1'b0);
      chk("R5 wd_state follows frame", wd_state, wd_model);
      ticks(per_of(c) - 1);
      chk($sformatf("R2/R7 code %0d before period", c), expired, 1'b0);
      ticks(1);
      chk($sformatf("R2/R7 code %0d at period", c), expired, 1'b1);
      ticks(3);
      chk("R8 sticky after extra ticks", expired, 1'b1);
      cyc(0, 1, wd_model, 0, 2'b00);
      chk("R4/R8 non-toggling frame keeps flag", expired, 1'b1);
    end

    // R6: write without toggle does not alter running period (active code 11)
    for (int c = 0; c < 4; c++) begin
      service_with_cfg(2'b11);
      cyc(0, 0, 0, 1, 2'(c));
      ticks(P3 - 1);
      chk($sformatf("R6 pending %0d not applied early", c), expired, 1'b0);
      ticks(1);
      chk($sformatf("R6 pending %0d old period kept", c), expired, 1'b1);
      service();
      ticks(per_of(c) - 1);
      chk($sformatf("R6 pending %0d before new period", c), expired, 1'b0);
      ticks(1);
      chk($sformatf("R6 pending %0d applied at next service", c), expired, 1'b1);
    end

    // R4: non-toggling filler frames mid-count do not restart
    service_with_cfg(2'b01);
    ticks(2);
    cyc(0, 1, wd_model, 0, 2'b00);
    cyc(1, 1, wd_model, 0, 2'b00);
    ticks(P1 - 4);
    chk("R4 filler frame no restart, before", expired, 1'b0);
    ticks(1);
    chk("R4 filler frame no restart, at period", expired, 1'b1);

    // R9: tick coincident with service is not counted
    service();
    ticks(2);
    cyc(1, 1, ~wd_model, 0, 2'b00);
    ticks(P1 - 1);
    chk("R9 coincident tick not counted", expired, 1'b0);
    ticks(1);
    chk("R9 expiry one tick later", expired, 1'b1);

    // R10: idle cycles without tick do not advance
    service();
    ticks(P1 - 1);
    repeat (50) @(negedge clk);
    chk("R10 idle cycles no progress", expired, 1'b0);
    ticks(1);
    chk("R10 expires on next tick", expired, 1'b1);

    // R5: frame_wd toggling with frame_ok low is ignored
    for (int i = 0; i < 4; i++) begin
      frame_wd = ~frame_wd;
      @(negedge clk);
      chk("R5 wd_state ignores bit without frame", wd_state, wd_model);
      chk("R5 flag unaffected without frame", expired, 1'b1);
    end
    cyc(0, 1, 1'b0, 0, 2'b00);
    cyc(0, 1, 1'b1, 0, 2'b00);
    chk("R5 wd_state after frame", wd_state, 1'b1);

    // R1: reset mid-run
    rst = 1; @(negedge clk); rst = 0; wd_model = 0;
    @(negedge clk);
    chk("R1 reset clears flag", expired, 1'b0);
    chk("R1 reset clears wd_state", wd_state, 1'b0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout of bench actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule